// File: doc/BRIEF.md
# Per-Pin Edge/Level Interrupt Detector

This block watches a small group of general-purpose input pins and raises one interrupt request line per pin. Each pin can be set up for edge detection or for level detection. In edge mode a rising edge, a falling edge, or both can be armed. A pin that sees an armed edge holds a sticky pending flag until software clears it. In level mode nothing is latched. The request line follows the pin while it sits at the chosen active level. The pins are asynchronous, so they pass through a two-flop synchroniser before any detection.

Software reaches the block through a simple word-indexed register port. Each of the two enable registers can be written three ways: a plain write of the whole word, a write-1-to-set alias and a write-1-to-clear alias. The pending status is cleared by writing 1s. Because of this, a driver can arm, disarm or acknowledge a single pin with one store and never needs a read-modify-write sequence. Priority, vectoring, pin multiplexing and wake-up are handled elsewhere.

Top module: `pin_irq_ctrl`

Register indices on `addr_i`: 0 mode (bit=1 level, 0 edge), 1 rise enable, 2 rise set-alias, 3 rise clear-alias, 4 fall enable, 5 fall set-alias, 6 fall clear-alias, 7 status. Bit n of every register belongs to pin n.

## Requirements
- R1: After reset, every register reads 0, `irq_o` is 0 and `rdata_o` is 0.
- R2: A write to index 1 or index 4 replaces the whole rise or fall enable register with `wdata_i`. A read at the same index (`rdata_o` valid on the edge after `re_i`) returns the stored value.
- R3: A write to index 2 or index 5 sets each rise or fall enable bit whose data bit is 1. Bits whose data bit is 0 keep their value.
- R4: A write to index 3 or index 6 clears each rise or fall enable bit whose data bit is 1. Bits whose data bit is 0 keep their value.
- R5: A read at any set-alias or clear-alias index returns the current value of the matching enable register.
- R6: In edge mode, a rising pin transition with its rise enable set drives that pin's `irq_o` bit high on the 3rd rising clock edge after the pin changes. The bit stays high after the pin returns low.
- R7: In edge mode, a falling transition with its fall enable set latches a pending flag in the same way. A transition whose enable bit is 0 latches nothing.
- R8: Writing 1 to a status bit (index 7) of an edge-mode pin clears both its rising and falling pending flags, and `irq_o` drops on that same edge. Status data bits that are 0 change nothing.
- R9: If a new armed edge and a write-1 status clear land on the same pin in the same cycle, the flag stays set.
- R10: In level mode, `irq_o` and the status bit are high while the rise enable bit is 1 and the synchronised pin is at its active level. The fall enable bit selects the active level: 0 means high, 1 means low. Nothing is latched, and status writes have no effect.
- R11: Reading status returns, per pin, the OR of its rising and falling pending flags (edge mode) or its level condition (level mode). The read has no side effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pin_i | input | NCH | Asynchronous pin inputs |
| addr_i | input | ADDR_W | Register index |
| wdata_i | input | DATA_W | Write data |
| we_i | input | 1 | Write strobe, takes effect on the clock edge |
| re_i | input | 1 | Read strobe; `rdata_o` updates on the clock edge |
| rdata_o | output | DATA_W | Registered read data, held between reads |
| irq_o | output | NCH | Registered per-pin interrupt request |

## Verification
A pin change reaches `irq_o` on the third rising edge: two synchroniser stages, then the edge compare that feeds the registered flag and output. The bench samples at the falling edge after the third rising edge. It also samples once a cycle early to confirm the output has not moved yet. Register writes and status clears act on the first rising edge, and read data appears one edge after the read strobe, so those checks sample at the next falling edge. The same-cycle collision test places the clear strobe so that it commits on exactly the edge where the new pin edge is captured.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  localparam int unsigned OFS_MODE     = 0;
  localparam int unsigned OFS_RISE     = 1;
  localparam int unsigned OFS_RISE_SET = 2;
  localparam int unsigned OFS_RISE_CLR = 3;
  localparam int unsigned OFS_FALL     = 4;
  localparam int unsigned OFS_FALL_SET = 5;
  localparam int unsigned OFS_FALL_CLR = 6;
  localparam int unsigned OFS_STATUS   = 7;

  typedef enum logic [1:0] {
    UPD_HOLD = 2'd0,
    UPD_LOAD = 2'd1,
    UPD_SET  = 2'd2,
    UPD_CLR  = 2'd3
  } upd_kind_e;
endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
  parameter int N      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] stg [STAGES];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
  import pin_irq_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [NCH-1:0]    status_i,
  output logic [NCH-1:0]    mode_o,
  output logic [NCH-1:0]    rise_en_o,
  output logic [NCH-1:0]    fall_en_o,
  output logic [NCH-1:0]    st_clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int NEN = 2;

  logic [NCH-1:0] wd;
  logic [NCH-1:0] mode_q;
  logic [NCH-1:0] en_q   [NEN];
  upd_kind_e      upd    [NEN];

  assign wd = wdata_i[NCH-1:0];

  function automatic upd_kind_e decode_upd(input logic [ADDR_W-1:0] a, input int unsigned base);
    if (a == ADDR_W'(base))          return UPD_LOAD;
    else if (a == ADDR_W'(base + 1)) return UPD_SET;
    else if (a == ADDR_W'(base + 2)) return UPD_CLR;
    else                             return UPD_HOLD;
  endfunction

  for (genvar k = 0; k < NEN; k++) begin : g_en
    localparam int unsigned BASE = (k == 0) ? OFS_RISE : OFS_FALL;

    always_comb begin
      upd[k] = we_i ? decode_upd(addr_i, BASE) : UPD_HOLD;
    end

    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        en_q[k] <= '0;
      end else begin
        case (upd[k])
          UPD_LOAD: en_q[k] <= wd;
          UPD_SET:  en_q[k] <= en_q[k] | wd;
          UPD_CLR:  en_q[k] <= en_q[k] & ~wd;
          default:  en_q[k] <= en_q[k];
        endcase
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mode_q <= '0;
    end else if (we_i && addr_i == ADDR_W'(OFS_MODE)) begin
      mode_q <= wd;
    end
  end

  assign st_clr_o = (we_i && addr_i == ADDR_W'(OFS_STATUS)) ? wd : '0;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rdata_o <= '0;
    end else if (re_i) begin
      if (addr_i == ADDR_W'(OFS_MODE))
        rdata_o <= DATA_W'(mode_q);
      else if (addr_i >= ADDR_W'(OFS_RISE) && addr_i <= ADDR_W'(OFS_RISE_CLR))
        rdata_o <= DATA_W'(en_q[0]);
      else if (addr_i >= ADDR_W'(OFS_FALL) && addr_i <= ADDR_W'(OFS_FALL_CLR))
        rdata_o <= DATA_W'(en_q[1]);
      else if (addr_i == ADDR_W'(OFS_STATUS))
        rdata_o <= DATA_W'(status_i);
      else
        rdata_o <= '0;
    end
  end

  assign mode_o    = mode_q;
  assign rise_en_o = en_q[0];
  assign fall_en_o = en_q[1];
endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect #(
  parameter int NCH = 8
) (
  input  logic           clk_i,
  input  logic           rst_i,
  input  logic [NCH-1:0] pin_s_i,
  input  logic [NCH-1:0] mode_i,
  input  logic [NCH-1:0] rise_en_i,
  input  logic [NCH-1:0] fall_en_i,
  input  logic [NCH-1:0] st_clr_i,
  output logic [NCH-1:0] status_o,
  output logic [NCH-1:0] rise_evt_o,
  output logic [NCH-1:0] fall_evt_o,
  output logic [NCH-1:0] irq_o
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic prev_q;
    logic flag_r_q, flag_f_q;
    logic flag_r_d, flag_f_d;
    logic lvl_act;
    logic irq_d;

    assign rise_evt_o[i] = pin_s_i[i] & ~prev_q;
    assign fall_evt_o[i] = ~pin_s_i[i] & prev_q;

    assign lvl_act = mode_i[i] & rise_en_i[i] & (pin_s_i[i] ^ fall_en_i[i]);

    always_comb begin
      if (mode_i[i]) begin
        flag_r_d = 1'b0;
        flag_f_d = 1'b0;
        irq_d    = lvl_act;
      end else begin
        flag_r_d = (flag_r_q & ~st_clr_i[i]) | (rise_evt_o[i] & rise_en_i[i]);
        flag_f_d = (flag_f_q & ~st_clr_i[i]) | (fall_evt_o[i] & fall_en_i[i]);
        irq_d    = flag_r_d | flag_f_d;
      end
    end

    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        prev_q   <= 1'b0;
        flag_r_q <= 1'b0;
        flag_f_q <= 1'b0;
        irq_o[i] <= 1'b0;
      end else begin
        prev_q   <= pin_s_i[i];
        flag_r_q <= flag_r_d;
        flag_f_q <= flag_f_d;
        irq_o[i] <= irq_d;
      end
    end

    assign status_o[i] = mode_i[i] ? lvl_act : (flag_r_q | flag_f_q);
  end
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl #(
  parameter int NCH         = 8,
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [NCH-1:0]    pin_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NCH-1:0]    irq_o
);
  logic [NCH-1:0] pin_s_w;
  logic [NCH-1:0] mode_w;
  logic [NCH-1:0] rise_en_w;
  logic [NCH-1:0] fall_en_w;
  logic [NCH-1:0] st_clr_w;
  logic [NCH-1:0] status_w;
  logic [NCH-1:0] rise_evt_w;
  logic [NCH-1:0] fall_evt_w;

  pin_irq_sync #(.N(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (pin_i),
    .q_o   (pin_s_w)
  );

  pin_irq_regs #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .we_i      (we_i),
    .re_i      (re_i),
    .status_i  (status_w),
    .mode_o    (mode_w),
    .rise_en_o (rise_en_w),
    .fall_en_o (fall_en_w),
    .st_clr_o  (st_clr_w),
    .rdata_o   (rdata_o)
  );

  pin_irq_detect #(.NCH(NCH)) u_det (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .pin_s_i    (pin_s_w),
    .mode_i     (mode_w),
    .rise_en_i  (rise_en_w),
    .fall_en_i  (fall_en_w),
    .st_clr_i   (st_clr_w),
    .status_o   (status_w),
    .rise_evt_o (rise_evt_w),
    .fall_evt_o (fall_evt_w),
    .irq_o      (irq_o)
  );
endmodule

// File: rtl/pin_irq_chk.sv
module pin_irq_chk
  import pin_irq_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              we_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [NCH-1:0]    irq_o,
  input logic [NCH-1:0]    mode,
  input logic [NCH-1:0]    rise_en,
  input logic [NCH-1:0]    fall_en,
  input logic [NCH-1:0]    rise_evt
);
  a_r1_reset_quiet: assert property (@(posedge clk_i)
    $past(rst_i) |-> (irq_o == '0 && rdata_o == '0));

  a_r3_rise_set_alias: assert property (@(posedge clk_i) disable iff (rst_i)
    (we_i && addr_i == ADDR_W'(OFS_RISE_SET)) |=>
      (rise_en == ($past(rise_en) | $past(wdata_i[NCH-1:0]))));

  a_r3_fall_set_alias: assert property (@(posedge clk_i) disable iff (rst_i)
    (we_i && addr_i == ADDR_W'(OFS_FALL_SET)) |=>
      (fall_en == ($past(fall_en) | $past(wdata_i[NCH-1:0]))));

  a_r4_rise_clr_alias: assert property (@(posedge clk_i) disable iff (rst_i)
    (we_i && addr_i == ADDR_W'(OFS_RISE_CLR)) |=>
      (rise_en == ($past(rise_en) & ~$past(wdata_i[NCH-1:0]))));

  a_r4_fall_clr_alias: assert property (@(posedge clk_i) disable iff (rst_i)
    (we_i && addr_i == ADDR_W'(OFS_FALL_CLR)) |=>
      (fall_en == ($past(fall_en) & ~$past(wdata_i[NCH-1:0]))));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    a_r8_edge_drop_needs_clear: assert property (@(posedge clk_i) disable iff (rst_i)
      ($fell(irq_o[i]) && !$past(mode[i]) && !$past(mode[i], 2)) |->
        $past(we_i && addr_i == ADDR_W'(OFS_STATUS) && wdata_i[i]));

    a_r9_edge_wins: assert property (@(posedge clk_i) disable iff (rst_i)
      $past(rise_evt[i] && rise_en[i] && !mode[i]) |-> irq_o[i]);

    a_r10_level_needs_enable: assert property (@(posedge clk_i) disable iff (rst_i)
      (irq_o[i] && $past(mode[i])) |-> $past(rise_en[i]));
  end
endmodule

bind pin_irq_ctrl pin_irq_chk #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .we_i     (we_i),
  .rdata_o  (rdata_o),
  .irq_o    (irq_o),
  .mode     (mode_w),
  .rise_en  (rise_en_w),
  .fall_en  (fall_en_w),
  .rise_evt (rise_evt_w)
);

// File: tb/pin_irq_ctrl_tb.sv
module pin_irq_ctrl_tb;
  localparam int NCH = 8;
  localparam int AW  = 4;
  localparam int DW  = 32;

  localparam logic [AW-1:0] A_MODE = 4'd0, A_RISE = 4'd1, A_RSET = 4'd2, A_RCLR = 4'd3;
  localparam logic [AW-1:0] A_FALL = 4'd4, A_FSET = 4'd5, A_FCLR = 4'd6, A_STAT = 4'd7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NCH-1:0] pin = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          we = 1'b0;
  logic          re = 1'b0;
  logic [DW-1:0] rdata;
  logic [NCH-1:0] irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pin_irq_ctrl #(.NCH(NCH), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk_i (clk), .rst_i (rst), .pin_i (pin), .addr_i (addr),
    .wdata_i (wdata), .we_i (we), .re_i (re), .rdata_o (rdata), .irq_o (irq)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    addr = a; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
    d = rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    check("R1 irq after reset", DW'(irq), '0);
    check("R1 rdata after reset", rdata, '0);
    for (int a = 0; a < 8; a++) begin
      rd(AW'(a), v);
      check($sformatf("R1 reg %0d after reset", a), v, '0);
    end
  endtask

  task automatic t_direct();
    logic [DW-1:0] v;
    wr(A_RISE, 32'hA5); rd(A_RISE, v); check("R2 rise direct write", v, 32'hA5);
    wr(A_FALL, 32'h3C); rd(A_FALL, v); check("R2 fall direct write", v, 32'h3C);
  endtask

  task automatic t_set();
    logic [DW-1:0] v;
    wr(A_RISE, 32'h01); wr(A_RSET, 32'h10); rd(A_RISE, v); check("R3 rise set alias", v, 32'h11);
    wr(A_FALL, 32'h00); wr(A_FSET, 32'h80); rd(A_FALL, v); check("R3 fall set alias", v, 32'h80);
  endtask

  task automatic t_clr();
    logic [DW-1:0] v;
    wr(A_RISE, 32'hFF); wr(A_RCLR, 32'h0F); rd(A_RISE, v); check("R4 rise clear alias", v, 32'hF0);
    wr(A_FCLR, 32'h80); rd(A_FALL, v); check("R4 fall clear alias", v, 32'h00);
  endtask

  task automatic t_alias_read();
    logic [DW-1:0] v;
    wr(A_RISE, 32'h5A); wr(A_FALL, 32'hC3);
    rd(A_RSET, v); check("R5 read rise set alias", v, 32'h5A);
    rd(A_RCLR, v); check("R5 read rise clear alias", v, 32'h5A);
    rd(A_FSET, v); check("R5 read fall set alias", v, 32'hC3);
    rd(A_FCLR, v); check("R5 read fall clear alias", v, 32'hC3);
  endtask

  task automatic edge_setup(input logic [7:0] r, input logic [7:0] f);
    pin = '0;
    wr(A_MODE, 0); wr(A_RISE, DW'(r)); wr(A_FALL, DW'(f));
    wait_n(4);
    wr(A_STAT, 32'hFF);
  endtask

  task automatic t_rise();
    logic [DW-1:0] v;
    edge_setup(8'h01, 8'h02);
    check("R6 idle irq", DW'(irq), 0);
    @(negedge clk); pin[0] = 1'b1;
    wait_n(2); check("R6 irq not early", DW'(irq), 0);
    wait_n(1); check("R6 irq on third edge", DW'(irq), 32'h01);
    pin[0] = 1'b0; wait_n(4);
    check("R6 sticky after pin low", DW'(irq), 32'h01);
    rd(A_STAT, v); check("R11 status shows flag", v, 32'h01);
    rd(A_STAT, v); check("R11 status read no side effect", v, 32'h01);
    wr(A_STAT, 32'h00); check("R8 zero data keeps flag", DW'(irq), 32'h01);
    wr(A_STAT, 32'h01); check("R8 write-1 clears flag", DW'(irq), 0);
  endtask

  task automatic t_fall();
    logic [DW-1:0] v;
    edge_setup(8'h01, 8'h02);
    @(negedge clk); pin[1] = 1'b1; wait_n(4);
    check("R7 disabled rising edge ignored", DW'(irq), 0);
    pin[1] = 1'b0; wait_n(3);
    check("R7 falling edge latched", DW'(irq), 32'h02);
    wr(A_STAT, 32'h02); check("R8 clear fall flag", DW'(irq), 0);
    edge_setup(8'h04, 8'h04);
    @(negedge clk); pin[2] = 1'b1; wait_n(4);
    pin[2] = 1'b0; wait_n(4);
    check("R11 both flags ORed", DW'(irq), 32'h04);
    wr(A_STAT, 32'h04); check("R8 both flags cleared irq", DW'(irq), 0);
    rd(A_STAT, v); check("R8 both flags cleared status", v, 0);
  endtask

  task automatic t_collide();
    logic [DW-1:0] v;
    edge_setup(8'h01, 8'h00);
    @(negedge clk); pin[0] = 1'b1; wait_n(4);
    pin[0] = 1'b0; wait_n(4);
    check("R9 flag set before collision", DW'(irq), 32'h01);
    pin[0] = 1'b1;
    wait_n(2);
    addr = A_STAT; wdata = 32'h01; we = 1'b1;
    @(negedge clk); we = 1'b0;
    check("R9 edge wins over clear irq", DW'(irq), 32'h01);
    rd(A_STAT, v); check("R9 edge wins over clear status", v, 32'h01);
    wr(A_STAT, 32'h01); check("R9 later clear works", DW'(irq), 0);
  endtask

  task automatic t_level();
    logic [DW-1:0] v;
    pin = '0;
    wr(A_MODE, 32'h10); wr(A_RISE, 32'h10); wr(A_FALL, 32'h00);
    wait_n(4);
    check("R10 level inactive", DW'(irq), 0);
    @(negedge clk); pin[4] = 1'b1;
    wait_n(2); check("R10 level not early", DW'(irq), 0);
    wait_n(1); check("R10 active high asserts", DW'(irq), 32'h10);
    rd(A_STAT, v); check("R11 level status", v, 32'h10);
    wr(A_STAT, 32'h10); wait_n(1); check("R10 status write no effect", DW'(irq), 32'h10);
    pin[4] = 1'b0; wait_n(3);
    check("R10 follows pin, no latch", DW'(irq), 0);
    wr(A_FSET, 32'h10); wait_n(1);
    check("R10 active low asserts", DW'(irq), 32'h10);
    pin[4] = 1'b1; wait_n(3);
    check("R10 active low releases", DW'(irq), 0);
    pin[4] = 1'b0; wr(A_RCLR, 32'h10); wait_n(3);
    check("R10 disabled level silent", DW'(irq), 0);
    rd(A_STAT, v); check("R10 disabled status", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_direct();
    t_set();
    t_clr();
    t_alias_read();
    t_rise();
    t_fall();
    t_collide();
    t_level();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule